// File: doc/BRIEF.md
# Asynchronous serial receiver with error flags

The block watches one serial receive line, finds the falling edge that opens a frame and confirms the start bit at its midpoint. It then samples every later bit at its midpoint, using a 16x oversampling tick taken from a plain clock divider. The data bits arrive least significant bit first and fill a shift register. An optional parity bit follows, then one or two stop bits. When the frame ends, the result moves into a holding register and the host sees it through a data-full flag, three error flags and two interrupt requests.

The host clears the data-full flag with a read-acknowledge pulse, and each error flag with its own clear strobe. The block will not start another frame while any error flag is set. A frame that ends while the holding register is still full is thrown away, and the overrun flag is raised. A frame with a bad stop bit or bad parity is still written into the holding register, but the data-full flag stays low and the matching error flag goes high.

Top module: `uart_rx_err`

## Requirements
- R1: The receive line passes through a two-flop synchronizer. A frame begins only at a high-to-low transition on the synchronized line, and only if the line is still low half a bit time (8 ticks) later. A shorter low pulse is ignored, and the receiver stays ready for the next edge.
- R2: Data bits are shifted in least significant bit first. With `len7_i`=0 a frame carries 8 data bits. With `len7_i`=1 it carries 7, and bit 7 of `rx_data_o` reads 0.
- R3: With `par_en_i`=1, one parity bit follows the data. With `par_odd_i`=0 the data bits plus the parity bit must hold an even number of ones, and with `par_odd_i`=1 an odd number. Otherwise `par_err_o` is set.
- R4: A first stop bit of 0 sets `frm_err_o`. With `two_stop_i`=1, the second stop bit is not checked and does not start a new frame.
- R5: A frame with no error that ends while `full_o`=0 loads `rx_data_o` and sets `full_o`. A `rd_ack_i` pulse clears `full_o`.
- R6: A frame that ends while `full_o`=1 sets `ovr_err_o` and leaves `rx_data_o` and `full_o` unchanged.
- R7: A frame that ends with `full_o`=0 but has a framing or parity error still loads `rx_data_o`, and leaves `full_o` at 0.
- R8: While any error flag is set, no frame is received. Each flag clears only through its own strobe (`clr_ovr_i`, `clr_frm_i`, `clr_par_i`). Reception resumes once all three flags are 0.
- R9: `rxi_o` = `full_o` AND `rie_i`. `eri_o` = (any error flag) AND `rie_i`.
- R10: After reset, `rx_data_o` is 0 and all flags and interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idles high |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | Two stop bits per frame |
| len7_i | input | 1 | 7 data bits instead of 8 |
| rie_i | input | 1 | Receive interrupt enable |
| rd_ack_i | input | 1 | Clears the data-full flag |
| clr_ovr_i | input | 1 | Clears the overrun flag |
| clr_frm_i | input | 1 | Clears the framing flag |
| clr_par_i | input | 1 | Clears the parity flag |
| rx_data_o | output | DW | Holding register |
| full_o | output | 1 | Data-full flag |
| ovr_err_o | output | 1 | Overrun flag |
| frm_err_o | output | 1 | Framing flag |
| par_err_o | output | 1 | Parity flag |
| rxi_o | output | 1 | Receive-data-full interrupt request |
| eri_o | output | 1 | Receive-error interrupt request |

## Verification
The assertions assume that the format inputs (`par_en_i`, `par_odd_i`, `two_stop_i`, `len7_i`) stay stable while a frame is in flight. They also assume the line returns high between frames, so that the falling-edge detector sees a fresh start. The stimulus changes the format inputs only while the line idles. It leaves at least one full bit time of idle high after each frame, and it issues strobes only after a frame has completely ended. The same-cycle collision of a flag's set and its clear is therefore never provoked from the bench.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       stop_ok;
    logic       par_ok;
  } rx_frame_t;
endpackage

// File: rtl/rxu_sync.sv
module rxu_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 2'b11;
    else         ff_q <= {ff_q[0], d_i};
  end
  assign q_o = ff_q[1];
endmodule

// File: rtl/rxu_tick.sv
module rxu_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (cnt_q == W'(DIV - 1)) cnt_q <= '0;
    else                           cnt_q <= cnt_q + W'(1);
  end
  assign tick_o = (cnt_q == W'(DIV - 1));
endmodule

// File: rtl/rxu_frame.sv
module rxu_frame
  import rxu_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      en_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  input  logic      two_stop_i,
  input  logic      len7_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OVS / 2;

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          prev_q, acc_q, pbit_q, stop_q, done_q;
  logic          bit_end;
  logic [BW-1:0] last_bit;

  assign bit_end  = (cnt_q == CW'(OVS - 1));
  assign last_bit = len7_i ? BW'(DW - 2) : BW'(DW - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      acc_q   <= 1'b0;
      pbit_q  <= 1'b0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        prev_q <= rx_i;
        case (state_q)
          ST_IDLE: if (en_i && prev_q && !rx_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              cnt_q <= '0;
              bit_q <= '0;
              acc_q <= 1'b0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;  // glitch -> back to idle
            end else cnt_q <= cnt_q + CW'(1);
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[DW-1:1]};
              acc_q <= acc_q ^ rx_i;
              if (bit_q == last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                   bit_q   <= bit_q + BW'(1);
            end else cnt_q <= cnt_q + CW'(1);
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt_q   <= '0;
              pbit_q  <= rx_i;
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + CW'(1);
          end
          ST_STOP: begin
            if (bit_end) begin
              cnt_q   <= '0;
              stop_q  <= rx_i;
              done_q  <= 1'b1;
              state_q <= two_stop_i ? ST_STOP2 : ST_IDLE;
            end else cnt_q <= cnt_q + CW'(1);
          end
          ST_STOP2: begin
            if (bit_end) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end else cnt_q <= cnt_q + CW'(1);
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o          = done_q;
  assign frame_o.data    = len7_i ? {1'b0, sh_q[DW-1:1]} : sh_q;
  assign frame_o.stop_ok = stop_q;
  assign frame_o.par_ok  = !par_en_i || ((acc_q ^ pbit_q) == par_odd_i);

  AST_IDLE_WHEN_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE)); // R8
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import rxu_pkg::*;
#(
  parameter int DIV = 4,
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  input  logic          len7_i,
  input  logic          rie_i,
  input  logic          rd_ack_i,
  input  logic          clr_ovr_i,
  input  logic          clr_frm_i,
  input  logic          clr_par_i,
  output logic [DW-1:0] rx_data_o,
  output logic          full_o,
  output logic          ovr_err_o,
  output logic          frm_err_o,
  output logic          par_err_o,
  output logic          rxi_o,
  output logic          eri_o
);
  logic      rx_s, tick, done, rx_en;
  rx_frame_t frame;
  logic [DW-1:0] data_q;
  logic full_q, ovr_q, frm_q, par_q;
  logic load, set_ovr, set_frm, set_par, set_full;

  rxu_sync u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s));

  rxu_tick #(.DIV(DIV)) u_tick (.clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  rxu_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_s), .en_i(rx_en),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .two_stop_i(two_stop_i),
    .len7_i(len7_i), .done_o(done), .frame_o(frame)
  );

  assign rx_en    = !(ovr_q || frm_q || par_q);
  assign set_ovr  = done && full_q;
  assign load     = done && !full_q;
  assign set_frm  = load && !frame.stop_ok;
  assign set_par  = load && !frame.par_ok;
  assign set_full = load && frame.stop_ok && frame.par_ok;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      if (load) data_q <= frame.data[DW-1:0];
      full_q <= set_full || (full_q && !rd_ack_i);
      ovr_q  <= set_ovr  || (ovr_q  && !clr_ovr_i);
      frm_q  <= set_frm  || (frm_q  && !clr_frm_i);
      par_q  <= set_par  || (par_q  && !clr_par_i);
    end
  end

  assign rx_data_o = data_q;
  assign full_o    = full_q;
  assign ovr_err_o = ovr_q;
  assign frm_err_o = frm_q;
  assign par_err_o = par_q;
  assign rxi_o     = full_q && rie_i;
  assign eri_o     = (ovr_q || frm_q || par_q) && rie_i;

  AST_OVR_HOLDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> ($stable(data_q) && full_q)); // R6
  AST_ERR_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(frm_q) || $rose(par_q)) |-> !full_q); // R7
  AST_FULL_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(done)); // R5
endmodule

// File: tb/uart_rx_err_bench.sv
module uart_rx_err_bench;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0, rst_ni = 1'b0, rx = 1'b1;
  logic par_en = 0, par_odd = 0, two_stop = 0, len7 = 0, rie = 1;
  logic rd_ack = 0, clr_ovr = 0, clr_frm = 0, clr_par = 0;
  logic [7:0] data;
  logic full, ovr, frm, par, rxi, eri;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  uart_rx_err #(.DIV(DIV)) u_uart_rx_err (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .par_en_i(par_en), .par_odd_i(par_odd),
    .two_stop_i(two_stop), .len7_i(len7), .rie_i(rie), .rd_ack_i(rd_ack),
    .clr_ovr_i(clr_ovr), .clr_frm_i(clr_frm), .clr_par_i(clr_par),
    .rx_data_o(data), .full_o(full), .ovr_err_o(ovr), .frm_err_o(frm),
    .par_err_o(par), .rxi_o(rxi), .eri_o(eri)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // start, data LSB first, optional parity, stop(s), one idle bit
  task automatic send(input logic [7:0] d, input int nb, input logic pb_on, input logic pb,
                      input logic s1, input logic s2);
    drive(1'b0, BIT);
    for (int i = 0; i < nb; i++) drive(d[i], BIT);
    if (pb_on) drive(pb, BIT);
    drive(s1, BIT);
    if (two_stop) drive(s2, BIT);
    drive(1'b1, BIT);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 data", data, 0); chk("R10 full", full, 0); chk("R10 ovr", ovr, 0);
    chk("R10 frm", frm, 0); chk("R10 par", par, 0); chk("R10 rxi", rxi, 0);
    chk("R10 eri", eri, 0);
  endtask

  task automatic t_clean;
    send(8'hA5, 8, 0, 0, 1, 1);
    chk("R2 data", data, 8'hA5); chk("R5 full", full, 1);
    chk("R9 rxi", rxi, 1); chk("R9 eri", eri, 0);
    pulse(rd_ack);
    chk("R5 ack", full, 0); chk("R9 rxi off", rxi, 0);
  endtask

  task automatic t_len7;
    len7 = 1;
    send(8'hCB, 7, 0, 0, 1, 1);
    chk("R2 len7 data", data, 8'h4B); chk("R2 len7 full", full, 1);
    pulse(rd_ack); len7 = 0;
  endtask

  task automatic t_parity;
    par_en = 1; par_odd = 0;
    send(8'h37, 8, 1, ^8'h37, 1, 1);
    chk("R3 even ok full", full, 1); chk("R3 even ok par", par, 0);
    pulse(rd_ack);
    par_odd = 1;
    send(8'h5E, 8, 1, ^8'h5E, 1, 1);  // wrong bit for odd parity
    chk("R3 odd bad par", par, 1); chk("R7 par data", data, 8'h5E);
    chk("R7 par full", full, 0); chk("R9 eri", eri, 1);
  endtask

  task automatic t_blocked;
    send(8'h11, 8, 1, ~^8'h11, 1, 1);
    chk("R8 blocked data", data, 8'h5E); chk("R8 blocked full", full, 0);
    pulse(clr_frm);
    chk("R8 other strobe", par, 1);
    pulse(clr_par);
    chk("R8 cleared", par, 0); chk("R9 eri off", eri, 0);
    send(8'h22, 8, 1, ~^8'h22, 1, 1);
    chk("R8 resume data", data, 8'h22); chk("R8 resume full", full, 1);
    pulse(rd_ack); par_en = 0; par_odd = 0;
  endtask

  task automatic t_framing;
    send(8'h81, 8, 0, 0, 0, 1);
    chk("R4 frm", frm, 1); chk("R7 frm data", data, 8'h81); chk("R7 frm full", full, 0);
    pulse(clr_frm);
    chk("R8 frm clear", frm, 0);
    two_stop = 1;
    send(8'h3C, 8, 0, 0, 1, 0);
    chk("R4 second stop ignored", frm, 0); chk("R4 two stop data", data, 8'h3C);
    chk("R4 two stop full", full, 1);
    pulse(rd_ack); two_stop = 0;
    send(8'h44, 8, 0, 0, 1, 1);
    chk("R4 no spurious frame", data, 8'h44);
    pulse(rd_ack);
  endtask

  task automatic t_overrun;
    send(8'h12, 8, 0, 0, 1, 1);
    send(8'h34, 8, 0, 0, 1, 1);
    chk("R6 ovr", ovr, 1); chk("R6 data kept", data, 8'h12);
    chk("R6 full kept", full, 1); chk("R9 eri ovr", eri, 1);
    pulse(rd_ack); pulse(clr_ovr);
    chk("R8 ovr clear", ovr, 0);
    send(8'h56, 8, 0, 0, 1, 1);
    chk("R8 after ovr", data, 8'h56);
    pulse(rd_ack);
  endtask

  task automatic t_rie_off;
    rie = 0;
    send(8'h9A, 8, 0, 0, 1, 1);
    chk("R9 rxi masked", rxi, 0); chk("R9 full", full, 1);
    send(8'h9B, 8, 0, 0, 1, 1);
    chk("R9 eri masked", eri, 0); chk("R6 ovr masked", ovr, 1);
    pulse(rd_ack); pulse(clr_ovr); rie = 1;
  endtask

  task automatic t_glitch;
    drive(1'b0, 3 * DIV);
    drive(1'b1, 2 * BIT);
    chk("R1 glitch full", full, 0); chk("R1 glitch err", ovr | frm | par, 0);
    send(8'hC3, 8, 0, 0, 1, 1);
    chk("R1 after glitch", data, 8'hC3); chk("R1 after glitch full", full, 1);
    pulse(rd_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (BIT) @(negedge clk);
    t_reset; t_clean; t_len7; t_parity; t_blocked;
    t_framing; t_overrun; t_rie_off; t_glitch;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule